// File: doc/BRIEF.md
# PHY Management Register File

This block holds the management registers of a 10/100 Ethernet physical-layer transceiver behind a simple parallel register bus: a 5-bit register address, a 16-bit write port and a 16-bit combinational read port. Software uses it to force or negotiate speed and duplex, to put the PHY in loopback, to disable scrambling, to read identity, status and link partner abilities, to count receive errors and to manage a single interrupt pin.

Bits follow mixed access rules. Some are plain read/write, some are read-only, one clears itself, some latch high and some latch low until read. Reads take effect at the clock edge at which `rd_en` is high: `rdata` shows the value held before that edge, and clear-on-read state is updated at the edge. Power-up values of the control register come from three strap pins. These are sampled on every clock while reset is low, so the value present when reset is released is the one kept.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While `rst_n` is low, control register 00h loads from `strap_mode`: bit 12 (negotiation enable) = NOT strap[2], bit 13 (100 Mbps) = strap[1], bit 8 (full duplex) = strap[0], and bit 14 = 0. Strap changes after reset release have no effect.
- R2: A write to 00h with bit 15 set restores 00h, 1Bh bits 9:8 and 1Fh bits 9 and 0 to their reset values. It uses the straps latched at the last reset, clears the error counter and the latched bits, and drives `sw_reset_o` high for exactly the next cycle. Bit 15 always reads 0.
- R3: 00h bit 14 is read/write and drives `loopback_o`.
- R4: While 00h bit 12 is set, `speed100_o`/`fdx_o` follow `res_speed100`/`res_fdx` and 00h bits 13 and 8 are ignored. When bit 12 is clear, the outputs follow bits 13 and 8.
- R5: Status 01h bit 2 (link) latches low. A low `link_up` clears it. It stays 0 until 01h is read, and that read loads the current `link_up`.
- R6: Status 01h bit 4 latches high while `remote_fault` is high and clears on a read of 01h.
- R7: 1Bh bit 0 sets on a rising edge of `link_up`, and 1Bh bit 1 sets on a rising edge of `remote_fault`. Both clear on a read of 1Bh. If an event and the read fall in the same cycle, the event wins.
- R8: `intr_o` is active when (1Bh[0] AND 1Bh[8]) OR (1Bh[1] AND 1Bh[9]). 1Fh bit 9 = 1 makes it active high, and 0 (the reset value) makes it active low.
- R9: 15h counts the cycles with `rx_err` high. It saturates at 16'hFFFF and clears on read. An error in the reading cycle leaves the count at 1.
- R10: 1Fh bits 4:2 give the operating mode. 000 means negotiation is enabled and `an_done` is low. Otherwise 001 = 10 half, 010 = 100 half, 101 = 10 full, 110 = 100 full, taken from the effective speed and duplex.
- R11: 1Fh bit 0 is read/write and drives `scramble_dis_o`.
- R12: Registers 01h, 02h, 03h and 05h are read-only and ignore writes. 02h/03h read the identifier parameters, 05h reads `partner_ability`, and 01h has constant bits 14:11, 3 and 0 set and bit 5 = `an_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_mode | input | 3 | Mode straps sampled during reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clear-on-read side effects) |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| link_up | input | 1 | Current link state |
| remote_fault | input | 1 | Remote fault indication |
| rx_err | input | 1 | Receive error, one count per cycle high |
| an_done | input | 1 | Auto-negotiation complete |
| res_speed100 | input | 1 | Negotiated speed is 100 Mbps |
| res_fdx | input | 1 | Negotiated duplex is full |
| partner_ability | input | 16 | Link partner ability word |
| sw_reset_o | output | 1 | One-cycle software reset pulse |
| loopback_o | output | 1 | Loopback enable |
| speed100_o | output | 1 | Effective speed is 100 Mbps |
| fdx_o | output | 1 | Effective full duplex |
| scramble_dis_o | output | 1 | Scrambler disable |
| intr_o | output | 1 | Interrupt pin, programmable polarity |

## Verification
A wrong latched bit is hidden until its register is read. Because `rdata` is combinational, the error shows on the port in the same cycle as the read. The same read shows whether the clear took effect at that edge, since a second read one cycle later returns the post-clear value.

A fault in the counter's saturation only shows after 65535 counted cycles. A fault in speed/duplex resolution or interrupt polarity reaches `speed100_o`, `fdx_o`, `intr_o` and the mode field without any register delay. A broken software reset shows on `sw_reset_o` and in 00h on the cycle after the write.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'h01;
  localparam logic [ADDR_W-1:0] A_ID_HI   = 5'h02;
  localparam logic [ADDR_W-1:0] A_ID_LO   = 5'h03;
  localparam logic [ADDR_W-1:0] A_PARTNER = 5'h05;
  localparam logic [ADDR_W-1:0] A_RXERR   = 5'h15;
  localparam logic [ADDR_W-1:0] A_INT     = 5'h1B;
  localparam logic [ADDR_W-1:0] A_VEND    = 5'h1F;

  // constant ability bits of the status register
  localparam logic [DATA_W-1:0] STAT_CONST = 16'h7809;

  typedef struct packed {
    logic loopback;
    logic speed100;
    logic an_en;
    logic fdx;
  } ctrl_t;

  // straps -> control defaults: [2]=forced mode, [1]=100M, [0]=full duplex
  function automatic ctrl_t strap_defaults(input logic [2:0] s);
    ctrl_t r;
    r.loopback = 1'b0;
    r.an_en    = ~s[2];
    r.speed100 = s[1];
    r.fdx      = s[0];
    return r;
  endfunction

  function automatic logic [2:0] op_mode_code(input logic an_en, input logic an_done,
                                              input logic spd, input logic fdx);
    if (an_en && !an_done) return 3'b000;
    return {fdx, spd, ~spd};
  endfunction
endpackage

// File: rtl/mgmt_rw_regs.sv
module mgmt_rw_regs
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              soft_req,
  output logic              sw_reset_q,
  output ctrl_t             ctrl_q,
  output logic [1:0]        int_en_q,
  output logic              int_pol_q,
  output logic              scr_dis_q
);
  logic [2:0] strap_q;
  logic       wr_ctrl, wr_int, wr_vend;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_int   = wr_en && (addr == A_INT);
  assign wr_vend  = wr_en && (addr == A_VEND);
  assign soft_req = wr_ctrl && wdata[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q    <= strap_mode;
      ctrl_q     <= strap_defaults(strap_mode);
      int_en_q   <= '0;
      int_pol_q  <= 1'b0;
      scr_dis_q  <= 1'b0;
      sw_reset_q <= 1'b0;
    end else begin
      sw_reset_q <= soft_req;
      if (soft_req) begin
        ctrl_q    <= strap_defaults(strap_q);
        int_en_q  <= '0;
        int_pol_q <= 1'b0;
        scr_dis_q <= 1'b0;
      end else begin
        if (wr_ctrl) begin
          ctrl_q.loopback <= wdata[14];
          ctrl_q.speed100 <= wdata[13];
          ctrl_q.an_en    <= wdata[12];
          ctrl_q.fdx      <= wdata[8];
        end
        if (wr_int) int_en_q <= wdata[9:8];
        if (wr_vend) begin
          int_pol_q <= wdata[9];
          scr_dis_q <= wdata[0];
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_latch_bits.sv
module mgmt_latch_bits #(
  parameter int           N         = 4,
  parameter logic [N-1:0] HIGH_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] rd,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic nxt;
    if (HIGH_MASK[i]) begin : g_high
      // set by event, cleared by read, event wins
      always_comb nxt = (rd[i] ? 1'b0 : q[i]) | ev[i];
    end else begin : g_low
      // cleared by low level, reloaded from live level on read
      always_comb nxt = rd[i] ? ev[i] : (q[i] & ev[i]);
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clr) q[i] <= 1'b0;
      else               q[i] <= nxt;
    end
  end
endmodule

// File: rtl/mgmt_sat_counter.sv
module mgmt_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ev,
  input  logic         rd_clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] base, input logic inc);
    if (inc && base != MAXV) return base + 1'b1;
    return base;
  endfunction

  logic [W-1:0] base;
  assign base = rd_clr ? '0 : q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else               q <= sat_step(base, ev);
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] ID_HI = 16'h1234,
  parameter logic [15:0] ID_LO = 16'h5678,
  parameter int          CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  strap_mode,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        link_up,
  input  logic        remote_fault,
  input  logic        rx_err,
  input  logic        an_done,
  input  logic        res_speed100,
  input  logic        res_fdx,
  input  logic [15:0] partner_ability,
  output logic        sw_reset_o,
  output logic        loopback_o,
  output logic        speed100_o,
  output logic        fdx_o,
  output logic        scramble_dis_o,
  output logic        intr_o
);
  localparam int NLAT = 4;
  // index: 0 link (low latch), 1 remote fault, 2 link-up irq, 3 fault irq
  localparam logic [NLAT-1:0] LAT_HIGH = 4'b1110;

  ctrl_t        ctrl_q;
  logic [1:0]   int_en_q;
  logic         int_pol_q;
  logic         soft_req;
  logic         link_d, rf_d;
  logic         rd_stat, rd_int, rd_cnt;
  logic [NLAT-1:0] lat_ev, lat_rd, lat_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]   op_mode;
  logic [1:0]   int_stat;
  logic         irq_req;

  mgmt_rw_regs u_rw (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .soft_req(soft_req), .sw_reset_q(sw_reset_o), .ctrl_q(ctrl_q),
    .int_en_q(int_en_q), .int_pol_q(int_pol_q), .scr_dis_q(scramble_dis_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_d <= 1'b0;
      rf_d   <= 1'b0;
    end else begin
      link_d <= link_up;
      rf_d   <= remote_fault;
    end
  end

  assign rd_stat = rd_en && (addr == A_STAT);
  assign rd_int  = rd_en && (addr == A_INT);
  assign rd_cnt  = rd_en && (addr == A_RXERR);

  assign lat_ev = {remote_fault & ~rf_d, link_up & ~link_d, remote_fault, link_up};
  assign lat_rd = {rd_int, rd_int, rd_stat, rd_stat};

  mgmt_latch_bits #(.N(NLAT), .HIGH_MASK(LAT_HIGH)) u_lat (
    .clk(clk), .rst_n(rst_n), .clr(soft_req),
    .ev(lat_ev), .rd(lat_rd), .q(lat_q)
  );

  mgmt_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(soft_req),
    .ev(rx_err), .rd_clr(rd_cnt), .q(cnt_q)
  );

  assign loopback_o = ctrl_q.loopback;
  assign speed100_o = ctrl_q.an_en ? res_speed100 : ctrl_q.speed100;
  assign fdx_o      = ctrl_q.an_en ? res_fdx      : ctrl_q.fdx;
  assign op_mode    = op_mode_code(ctrl_q.an_en, an_done, speed100_o, fdx_o);

  assign int_stat = lat_q[3:2];
  assign irq_req  = |(int_stat & int_en_q);
  assign intr_o   = int_pol_q ? irq_req : ~irq_req;

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:    rdata = {1'b0, ctrl_q.loopback, ctrl_q.speed100, ctrl_q.an_en,
                          3'b000, ctrl_q.fdx, 8'h00};
      A_STAT:    rdata = STAT_CONST | {10'b0, an_done, lat_q[1], 1'b0, lat_q[0], 2'b00};
      A_ID_HI:   rdata = ID_HI;
      A_ID_LO:   rdata = ID_LO;
      A_PARTNER: rdata = partner_ability;
      A_RXERR:   rdata = 16'(cnt_q);
      A_INT:     rdata = {6'b0, int_en_q, 6'b0, int_stat};
      A_VEND:    rdata = {6'b0, int_pol_q, 4'b0, op_mode, 1'b0, scramble_dis_o};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [4:0]       addr,
  input logic             soft_req,
  input logic             sw_reset_o,
  input logic             loopback_o,
  input logic             scramble_dis_o,
  input logic             rx_err,
  input logic [CNT_W-1:0] cnt_q,
  input logic [3:0]       lat_q,
  input logic             an_done,
  input logic [15:0]      rdata,
  input logic             intr_o,
  input logic             int_pol_q
);
  logic rd_stat, rd_cnt, rd_int;
  assign rd_stat = rd_en && addr == 5'h01;
  assign rd_cnt  = rd_en && addr == 5'h15;
  assign rd_int  = rd_en && addr == 5'h1B;

  p_sreset_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_req |=> sw_reset_o && !loopback_o && !scramble_dis_o);

  p_ll_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_q[0] && !rd_stat) |=> !lat_q[0]);

  p_lh_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[1] && !rd_stat && !soft_req) |=> lat_q[1]);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[2] && !rd_int && !soft_req) |=> lat_q[2]);

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[3:2] == 2'b00) |-> (intr_o == ~int_pol_q));

  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_q && !rd_cnt && !soft_req) |=> &cnt_q);

  p_cnt_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt && !rx_err) |=> cnt_q == '0);

  p_opmode_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 5'h1F && rdata[12] == 1'b0 && !an_done && $countones(rdata[4:2]) != 0)
      |-> (rdata[3:2] != 2'b00));
endmodule

bind phy_mgmt_regs phy_mgmt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
  .soft_req(soft_req), .sw_reset_o(sw_reset_o), .loopback_o(loopback_o),
  .scramble_dis_o(scramble_dis_o), .rx_err(rx_err), .cnt_q(cnt_q),
  .lat_q(lat_q), .an_done(an_done), .rdata(rdata), .intr_o(intr_o),
  .int_pol_q(int_pol_q)
);

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  strap_mode = 3'b011;
  logic        wr_en = 0, rd_en = 0;
  logic [4:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        link_up = 0, remote_fault = 0, rx_err = 0, an_done = 0;
  logic        res_speed100 = 0, res_fdx = 0;
  logic [15:0] partner_ability = 16'hA5C3;
  logic        sw_reset_o, loopback_o, speed100_o, fdx_o, scramble_dis_o, intr_o;

  int n_tests = 0, n_fail = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  phy_mgmt_regs u_dut (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .link_up(link_up),
    .remote_fault(remote_fault), .rx_err(rx_err), .an_done(an_done),
    .res_speed100(res_speed100), .res_fdx(res_fdx), .partner_ability(partner_ability),
    .sw_reset_o(sw_reset_o), .loopback_o(loopback_o), .speed100_o(speed100_o),
    .fdx_o(fdx_o), .scramble_dis_o(scramble_dis_o), .intr_o(intr_o)
  );

  // {is_write, addr, data, mask}
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'h00, 16'h3100, 16'hFFFF},  // R1 strap 011
    {1'b1, 5'h00, 16'h4000, 16'h0000},
    {1'b0, 5'h00, 16'h4000, 16'hFFFF},  // R3
    {1'b1, 5'h1F, 16'h0201, 16'h0000},
    {1'b0, 5'h1F, 16'h0201, 16'h0203},  // R11
    {1'b1, 5'h1B, 16'h0300, 16'h0000},
    {1'b0, 5'h1B, 16'h0300, 16'h0300},  // R8 enables
    {1'b1, 5'h02, 16'hFFFF, 16'h0000},
    {1'b0, 5'h02, 16'h1234, 16'hFFFF},  // R12
    {1'b1, 5'h05, 16'h0000, 16'h0000},
    {1'b0, 5'h05, 16'hA5C3, 16'hFFFF},  // R12
    {1'b1, 5'h03, 16'h0000, 16'h0000},
    {1'b0, 5'h03, 16'h5678, 16'hFFFF}   // R12
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [15:0] d);
    rd_en = 1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic hw_reset(input logic [2:0] s);
    rst_n = 0; strap_mode = s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    hw_reset(3'b011);
    strap_mode = 3'b100;  // R1: post-release change ignored
    @(posedge clk); #1;
    chk({15'b0, intr_o}, 16'h1, "R8 reset pin inactive-low idle");
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) do_write(VEC[i][36:32], VEC[i][31:16]);
      else begin
        peek(VEC[i][36:32], rv);
        chk(rv & VEC[i][15:0], VEC[i][31:16] & VEC[i][15:0], $sformatf("R1/R3/R11/R12 vec %0d", i));
      end
    end
    chk({15'b0, loopback_o}, 16'h1, "R3 loopback_o");
    chk({15'b0, scramble_dis_o}, 16'h1, "R11 scramble_dis_o");
    do_write(5'h01, 16'h0000);
    peek(5'h01, rv);
    chk(rv, 16'h7809, "R12 status ignores write");

    // R1 second strap pattern, R2 soft reset
    hw_reset(3'b110);
    peek(5'h00, rv);
    chk(rv, 16'h2000, "R1 strap 110");
    strap_mode = 3'b001;
    do_write(5'h1F, 16'h0201);
    do_write(5'h00, 16'h4100);
    do_write(5'h00, 16'h8000);
    chk({15'b0, sw_reset_o}, 16'h1, "R2 pulse");
    peek(5'h00, rv);
    chk(rv, 16'h2000, "R2 defaults restored, bit15 reads 0");
    peek(5'h1F, rv);
    chk(rv & 16'h0201, 16'h0000, "R2 vendor bits restored");
    @(posedge clk); #1;
    chk({15'b0, sw_reset_o}, 16'h0, "R2 pulse one cycle");

    // R4 / R10
    res_speed100 = 0; res_fdx = 1;
    chk({14'b0, speed100_o, fdx_o}, 16'h2, "R4 forced 100 half");
    peek(5'h1F, rv);
    chk((rv >> 2) & 16'h7, 16'h2, "R10 100 half");
    do_write(5'h00, 16'h3100);
    chk({14'b0, speed100_o, fdx_o}, 16'h1, "R4 negotiated overrides bits 13/8");
    peek(5'h1F, rv);
    chk((rv >> 2) & 16'h7, 16'h0, "R10 negotiating");
    an_done = 1;
    peek(5'h1F, rv);
    chk((rv >> 2) & 16'h7, 16'h5, "R10 10 full");
    do_write(5'h00, 16'h2100);
    peek(5'h1F, rv);
    chk((rv >> 2) & 16'h7, 16'h6, "R10 100 full");
    do_write(5'h00, 16'h0000);
    peek(5'h1F, rv);
    chk((rv >> 2) & 16'h7, 16'h1, "R10 10 half");

    // R5 latch-low link
    link_up = 1;
    @(posedge clk); #1;
    do_read(5'h01, rv);
    chk(rv & 16'h0004, 16'h0000, "R5 first read latched 0");
    do_read(5'h01, rv);
    chk(rv & 16'h0004, 16'h0004, "R5 link now 1");
    link_up = 0; @(posedge clk); #1; link_up = 1; @(posedge clk); #1;
    do_read(5'h01, rv);
    chk(rv & 16'h0004, 16'h0000, "R5 drop latched");
    do_read(5'h01, rv);
    chk(rv & 16'h0004, 16'h0004, "R5 recovered");

    // R7/R8: link-up irq from the last rising edge is pending
    do_write(5'h1B, 16'h0100);
    chk({15'b0, intr_o}, 16'h0, "R8 active-low asserted");
    do_write(5'h1F, 16'h0200);
    chk({15'b0, intr_o}, 16'h1, "R8 active-high asserted");
    do_read(5'h1B, rv);
    chk(rv & 16'h0003, 16'h0001, "R7 link-up status");
    chk({15'b0, intr_o}, 16'h0, "R8 cleared by read");

    // R6 / R7 remote fault
    remote_fault = 1; @(posedge clk); #1; remote_fault = 0; @(posedge clk); #1;
    do_read(5'h01, rv);
    chk(rv & 16'h0010, 16'h0010, "R6 latched high");
    do_read(5'h01, rv);
    chk(rv & 16'h0010, 16'h0000, "R6 cleared on read");
    chk({15'b0, intr_o}, 16'h0, "R8 fault irq masked");
    do_read(5'h1B, rv);
    chk(rv & 16'h0003, 16'h0002, "R7 fault status");
    do_read(5'h1B, rv);
    chk(rv & 16'h0003, 16'h0000, "R7 cleared");

    // R9 counter
    repeat (5) begin rx_err = 1; @(posedge clk); #1; rx_err = 0; @(posedge clk); #1; end
    do_read(5'h15, rv);
    chk(rv, 16'd5, "R9 count 5");
    rx_err = 1;
    do_read(5'h15, rv);
    rx_err = 0;
    chk(rv, 16'd0, "R9 cleared");
    peek(5'h15, rv);
    chk(rv, 16'd1, "R9 event during read");
    rx_err = 1;
    repeat (65540) @(posedge clk);
    #1 rx_err = 0;
    do_read(5'h15, rv);
    chk(rv, 16'hFFFF, "R9 saturate");
    peek(5'h15, rv);
    chk(rv, 16'h0000, "R9 clear after saturate");

    finish_run();
  end
endmodule